// File: doc/BRIEF.md
# Complementary Dead-Time Gate Generator

This block turns a frequency request into the two gate signals of a half-bridge. A switching cycle is two equal halves: the low-side half first, then the high-side half. In each half, both gates stay low for a dead interval, and then the gate that owns that half is high for the rest of it. Each gate therefore covers half the period, and the dead interval is counted inside that half.

The frequency request comes from the regulation loop as a code. A larger code gives a shorter half-period and so a higher frequency. The half-period has a floor that keeps the switching frequency at or below 600 kHz. The dead-time code has two reserved values, for a shorted and an open setting, and every other value is clamped into the usable window. A pulse-skip level with two thresholds stops and restarts switching under light load. The skip logic and the period logic take effect only on cycle boundaries, so neither one cuts a pulse short. An enable input turns both gates off at once.

A strobe marks the first clock of each cycle for the protection logic. All timing is in clocks of a 200 MHz reference (5 ns).

Top module: `halfbr_gate_gen`

## Requirements
- R1: `lo_o` and `ho_o` are never both 1, and both are 0 while reset is asserted.
- R2: A cycle of half-period H and dead time D lasts 2H clocks. In clocks 0..H-1, `lo_o` is 1 only from clock D on. In clocks H..2H-1, `ho_o` is 1 only from clock H+D on. `cyc_start_o` is 1 in clock 0 only, and cycles follow back to back.
- R3: H = 1100 - `freq_code_i` (10-bit code), so a larger code gives a higher frequency.
- R4: H is never below 167 clocks (835 ns, which keeps the frequency at or below 600 kHz). Codes 933 and above give H = 167, and code 932 gives 168.
- R5: A `dt_code_i` value from 1 to 254 gives D = code clocks, clamped to the range 20..120 (100..600 ns).
- R6: `dt_code_i` = 0 (shorted) gives D = 10 clocks (50 ns), and `dt_code_i` = 255 (open) gives D = 200 clocks (1000 ns).
- R7: D is limited to H-1, so every gate pulse is at least one clock long.
- R8: H and D are sampled at the start of a cycle. A code change during a cycle affects only the next cycle.
- R9: Skip hysteresis on `skip_lvl_i` (units of 10 mV): switching stops when the level is below 40 and resumes only once it is above 60. Levels from 40 to 60 keep the current state. After reset the state is "stopped".
- R10: A skip stop lets the current cycle finish. A resume begins a full low-side-first cycle two clocks after the level first reads above 60.
- R11: When `en_i` is 0, both gates and the strobe are 0 in the same clock. When `en_i` returns to 1, a fresh low-side-first cycle starts on the next clock edge.
- R12: After reset is released with the enable on and the skip level high, the first cycle starts at the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 200 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Switching enable; 0 forces both gates off at once |
| freq_code_i | input | 10 | Frequency request; larger means faster |
| dt_code_i | input | 8 | Dead-time code; 0 means shorted, 255 means open |
| skip_lvl_i | input | 8 | Pulse-skip control level in 10 mV steps |
| lo_o | output | 1 | Low-side gate |
| ho_o | output | 1 | High-side gate |
| cyc_start_o | output | 1 | One-clock strobe at the start of each cycle |

## Verification
Each gate is derived from a shared phase counter and a side bit. A counter or a latched half-period that goes wrong therefore shows up within one cycle, as a pulse edge that lands on the wrong clock or a strobe that does not return after 2H clocks. If the dead value is sampled at the wrong time, the change in pulse width appears in the same cycle as the code change rather than one cycle later. If the skip state is wrong, the bench sees pulses while the level sits between the thresholds, or a truncated final cycle. The bench compares every clock of a cycle against the expected waveform, so these faults are caught at the exact clock where they first appear.

// File: rtl/halfbr_pkg.sv
package halfbr_pkg;
  typedef enum logic {
    SIDE_LO = 1'b0,
    SIDE_HI = 1'b1
  } side_e;
endpackage

// File: rtl/halfbr_period_map.sv
module halfbr_period_map #(
  parameter int FREQ_W   = 10,
  parameter int MAX_HALF = 1100,
  parameter int MIN_HALF = 167,
  parameter int HALF_W   = 11
) (
  input  logic [FREQ_W-1:0] freq_code_i,
  output logic [HALF_W-1:0] half_o
);
  int raw;

  always_comb begin
    raw = MAX_HALF - int'(freq_code_i);
    if (raw < MIN_HALF) half_o = HALF_W'(MIN_HALF);
    else                half_o = HALF_W'(raw);
  end
endmodule

// File: rtl/halfbr_dead_map.sv
module halfbr_dead_map #(
  parameter int DT_W     = 8,
  parameter int HALF_W   = 11,
  parameter int DT_SHORT = 10,
  parameter int DT_OPEN  = 200,
  parameter int DT_MIN   = 20,
  parameter int DT_MAX   = 120
) (
  input  logic [DT_W-1:0]   dt_code_i,
  input  logic [HALF_W-1:0] half_i,
  output logic [HALF_W-1:0] dead_o
);
  localparam int CODE_OPEN = (1 << DT_W) - 1;

  int want;
  int lim;

  always_comb begin
    if (int'(dt_code_i) == 0)              want = DT_SHORT;
    else if (int'(dt_code_i) == CODE_OPEN) want = DT_OPEN;
    else if (int'(dt_code_i) < DT_MIN)     want = DT_MIN;
    else if (int'(dt_code_i) > DT_MAX)     want = DT_MAX;
    else                                   want = int'(dt_code_i);
    // keep at least one active clock per half
    lim = int'(half_i) - 1;
    if (want > lim) want = lim;
    dead_o = HALF_W'(want);
  end
endmodule

// File: rtl/halfbr_skip_hyst.sv
module halfbr_skip_hyst #(
  parameter int SKIP_W  = 8,
  parameter int SKIP_LO = 40,
  parameter int SKIP_HI = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SKIP_W-1:0] skip_lvl_i,
  output logic              ok_o
);
  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q <= 1'b0;
    end else if (ok_q && (int'(skip_lvl_i) < SKIP_LO)) begin
      ok_q <= 1'b0;
    end else if (!ok_q && (int'(skip_lvl_i) > SKIP_HI)) begin
      ok_q <= 1'b1;
    end
  end

  assign ok_o = ok_q;

  // R9
  skip_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_q) |-> (int'($past(skip_lvl_i)) > SKIP_HI));
  // R9
  skip_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ok_q) |-> (int'($past(skip_lvl_i)) < SKIP_LO));
endmodule

// File: rtl/halfbr_phase_seq.sv
module halfbr_phase_seq
  import halfbr_pkg::*;
#(
  parameter int HALF_W   = 11,
  parameter int MIN_HALF = 167
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ok_i,
  input  logic [HALF_W-1:0] half_req_i,
  input  logic [HALF_W-1:0] dead_req_i,
  output logic              run_o,
  output side_e             side_o,
  output logic              act_o,
  output logic              start_o
);
  logic [HALF_W-1:0] cnt_q, half_q, dead_q;
  side_e             side_q;
  logic              run_q;
  logic              last_c;

  assign last_c = (cnt_q == half_q - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      side_q <= SIDE_LO;
      half_q <= HALF_W'(MIN_HALF);
      dead_q <= '0;
    end else if (!run_q) begin
      cnt_q  <= '0;
      side_q <= SIDE_LO;
      if (en_i && ok_i) begin
        run_q  <= 1'b1;
        half_q <= half_req_i;
        dead_q <= dead_req_i;
      end
    end else if (!en_i) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      side_q <= SIDE_LO;
    end else if (last_c) begin
      cnt_q <= '0;
      if (side_q == SIDE_LO) begin
        side_q <= SIDE_HI;
      end else begin
        // cycle boundary: resample codes, apply skip decision
        side_q <= SIDE_LO;
        half_q <= half_req_i;
        dead_q <= dead_req_i;
        run_q  <= ok_i;
      end
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  assign run_o   = run_q;
  assign side_o  = side_q;
  assign act_o   = (cnt_q >= dead_q);
  assign start_o = run_q && (cnt_q == '0) && (side_q == SIDE_LO);

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < half_q));
  // R4
  half_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (int'(half_q) >= MIN_HALF));
  // R7
  dead_in_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (dead_q < half_q));
  // R8
  hold_mid_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !(last_c && side_q == SIDE_HI)) |=> ($stable(half_q) && $stable(dead_q)));
  // R10
  stop_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> (!$past(en_i) || ($past(last_c) && $past(side_q) == SIDE_HI)));
endmodule

// File: rtl/halfbr_gate_gen.sv
module halfbr_gate_gen
  import halfbr_pkg::*;
#(
  parameter int CLK_KHZ     = 200000,
  parameter int FMAX_KHZ    = 600,
  parameter int FREQ_W      = 10,
  parameter int MAX_HALF    = 1100,
  parameter int DT_W        = 8,
  parameter int DT_SHORT_NS = 50,
  parameter int DT_OPEN_NS  = 1000,
  parameter int DT_MIN_NS   = 100,
  parameter int DT_MAX_NS   = 600,
  parameter int SKIP_W      = 8,
  parameter int SKIP_LO     = 40,
  parameter int SKIP_HI     = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FREQ_W-1:0] freq_code_i,
  input  logic [DT_W-1:0]   dt_code_i,
  input  logic [SKIP_W-1:0] skip_lvl_i,
  output logic              lo_o,
  output logic              ho_o,
  output logic              cyc_start_o
);
  localparam int NS_PER_CYC = 1000000 / CLK_KHZ;
  localparam int MIN_HALF   = (CLK_KHZ + 2 * FMAX_KHZ - 1) / (2 * FMAX_KHZ);
  localparam int HALF_W     = $clog2(MAX_HALF + 1);
  localparam int DT_SHORT   = DT_SHORT_NS / NS_PER_CYC;
  localparam int DT_OPEN    = DT_OPEN_NS / NS_PER_CYC;
  localparam int DT_MIN     = DT_MIN_NS / NS_PER_CYC;
  localparam int DT_MAX     = DT_MAX_NS / NS_PER_CYC;

  logic [HALF_W-1:0] half_req, dead_req;
  logic              skip_ok, run, act, start;
  side_e             side;
  logic [1:0]        gate;

  halfbr_period_map #(
    .FREQ_W(FREQ_W), .MAX_HALF(MAX_HALF), .MIN_HALF(MIN_HALF), .HALF_W(HALF_W)
  ) u_period (
    .freq_code_i(freq_code_i),
    .half_o     (half_req)
  );

  halfbr_dead_map #(
    .DT_W(DT_W), .HALF_W(HALF_W), .DT_SHORT(DT_SHORT), .DT_OPEN(DT_OPEN),
    .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)
  ) u_dead (
    .dt_code_i(dt_code_i),
    .half_i   (half_req),
    .dead_o   (dead_req)
  );

  halfbr_skip_hyst #(
    .SKIP_W(SKIP_W), .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI)
  ) u_skip (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .skip_lvl_i(skip_lvl_i),
    .ok_o      (skip_ok)
  );

  halfbr_phase_seq #(
    .HALF_W(HALF_W), .MIN_HALF(MIN_HALF)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .ok_i      (skip_ok),
    .half_req_i(half_req),
    .dead_req_i(dead_req),
    .run_o     (run),
    .side_o    (side),
    .act_o     (act),
    .start_o   (start)
  );

  // one gate per side; enable cuts both without waiting for a clock
  for (genvar g = 0; g < 2; g++) begin : g_side
    assign gate[g] = run && en_i && act && (side == ((g == 0) ? SIDE_LO : SIDE_HI));
  end

  assign lo_o        = gate[0];
  assign ho_o        = gate[1];
  assign cyc_start_o = start && en_i;

  // R1
  excl_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_o && ho_o));
  // R1
  always_comb begin
    if (!rst_ni) reset_quiet_chk: assert (!lo_o && !ho_o);
  end
  // R11
  en_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!lo_o && !ho_o && !cyc_start_o));
endmodule

// File: tb/halfbr_gate_gen_tb_top.sv
`timescale 1ns/1ps
module halfbr_gate_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic [9:0] freq_code_i = 10'd900;
  logic [7:0] dt_code_i = 8'd40;
  logic [7:0] skip_lvl_i = 8'd100;
  logic       lo_o, ho_o, cyc_start_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  halfbr_gate_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .freq_code_i(freq_code_i),
    .dt_code_i(dt_code_i), .skip_lvl_i(skip_lvl_i),
    .lo_o(lo_o), .ho_o(ho_o), .cyc_start_o(cyc_start_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wait_strobe(input string tag);
    int n = 0;
    do begin
      step();
      n++;
    end while (!cyc_start_o && n < 5000);
    chk(cyc_start_o === 1'b1, tag, n, -1);
  endtask

  // starts at the sample of clock 0 of a cycle
  task automatic check_cycle(input int h, input int d, input bit cont, input string tag);
    int nerr = 0;
    int first = -1;
    int act = 0;
    int exp = 0;
    for (int i = 0; i < 2 * h; i++) begin
      logic el, eh, es;
      if (i > 0) step();
      el = (i < h) && (i >= d);
      eh = (i >= h) && ((i - h) >= d);
      es = (i == 0);
      if (lo_o !== el || ho_o !== eh || cyc_start_o !== es || (lo_o && ho_o)) begin
        nerr++;
        if (first < 0) begin
          first = i;
          act = {lo_o, ho_o, cyc_start_o};
          exp = {el, eh, es};
        end
      end
    end
    if (nerr != 0) $display("  %s first mismatch at clock %0d (lo,ho,stb bits)", tag, first);
    chk(nerr == 0, tag, act, exp);
    if (cont) begin
      step();
      chk(cyc_start_o === 1'b1, {tag, " next-start"}, int'(cyc_start_o), 1);
    end
  endtask

  task automatic set_and_check(input int fc, input int dc, input int h, input int d, input string tag);
    wait_strobe(tag);
    freq_code_i = 10'(fc);
    dt_code_i   = 8'(dc);
    wait_strobe(tag);
    check_cycle(h, d, 1'b1, tag);
  endtask

  task automatic t_reset();
    #1;
    chk(!lo_o && !ho_o && !cyc_start_o, "R1 reset quiet", {lo_o, ho_o, cyc_start_o}, 0);
    repeat (3) @(negedge clk_i);
    chk(!lo_o && !ho_o && !cyc_start_o, "R1 reset quiet later", {lo_o, ho_o, cyc_start_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk(cyc_start_o === 1'b0, "R12 no start at edge 1", int'(cyc_start_o), 0);
    step();
    chk(cyc_start_o === 1'b1, "R12 start at edge 2", int'(cyc_start_o), 1);
    check_cycle(200, 40, 1'b1, "R2 first cycle");
  endtask

  task automatic t_freq();
    set_and_check(900, 40, 200, 40, "R3 code 900");
    set_and_check(500, 30, 600, 30, "R3 code 500 slower");
    set_and_check(1023, 40, 167, 40, "R4 code 1023 floor");
    set_and_check(933, 40, 167, 40, "R4 code 933 floor edge");
    set_and_check(932, 40, 168, 40, "R4 code 932 above floor");
  endtask

  task automatic t_dead();
    set_and_check(900, 0, 200, 10, "R6 shorted");
    set_and_check(500, 255, 600, 200, "R6 open");
    set_and_check(900, 5, 200, 20, "R5 low clamp");
    set_and_check(900, 200, 200, 120, "R5 high clamp");
    set_and_check(900, 100, 200, 100, "R5 pass-through");
    set_and_check(1023, 255, 167, 166, "R7 dead limited by half");
  endtask

  task automatic t_sample();
    set_and_check(900, 40, 200, 40, "R8 setup");
    freq_code_i = 10'd500;
    dt_code_i   = 8'd60;
    check_cycle(200, 40, 1'b1, "R8 old codes held");
    check_cycle(600, 60, 1'b1, "R8 new codes next cycle");
    freq_code_i = 10'd900;
    dt_code_i   = 8'd40;
    check_cycle(600, 60, 1'b1, "R8 restore");
  endtask

  task automatic t_skip();
    int seen = 0;
    check_cycle(200, 40, 1'b1, "R9 settle");
    skip_lvl_i = 8'd50;
    check_cycle(200, 40, 1'b1, "R9 mid level keeps running");
    skip_lvl_i = 8'd30;
    check_cycle(200, 40, 1'b0, "R10 stop finishes cycle");
    step();
    chk(!lo_o && !ho_o && !cyc_start_o, "R10 idle after stop", {lo_o, ho_o, cyc_start_o}, 0);
    skip_lvl_i = 8'd50;
    for (int i = 0; i < 40; i++) begin
      step();
      if (lo_o || ho_o || cyc_start_o) seen++;
    end
    chk(seen == 0, "R9 mid level stays stopped", seen, 0);
    skip_lvl_i = 8'd60;
    step();
    step();
    chk(cyc_start_o === 1'b0, "R9 level 60 not above threshold", int'(cyc_start_o), 0);
    skip_lvl_i = 8'd70;
    step();
    chk(cyc_start_o === 1'b0, "R10 resume not yet", int'(cyc_start_o), 0);
    step();
    chk(cyc_start_o === 1'b1, "R10 resume strobe", int'(cyc_start_o), 1);
    check_cycle(200, 40, 1'b1, "R10 full cycle after resume");
  endtask

  task automatic t_enable();
    repeat (45) step();
    chk(lo_o === 1'b1, "R11 low side active before cut", int'(lo_o), 1);
    en_i = 1'b0;
    #0.5;
    chk(!lo_o && !ho_o && !cyc_start_o, "R11 immediate cut", {lo_o, ho_o, cyc_start_o}, 0);
    repeat (5) step();
    chk(!lo_o && !ho_o && !cyc_start_o, "R11 stays off", {lo_o, ho_o, cyc_start_o}, 0);
    en_i = 1'b1;
    step();
    chk(cyc_start_o === 1'b1, "R11 fresh start", int'(cyc_start_o), 1);
    check_cycle(200, 40, 1'b1, "R11 cycle after re-enable");
  endtask

  initial begin
    t_reset();
    t_freq();
    t_dead();
    t_sample();
    t_skip();
    t_enable();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule